// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block sequences the host-side strobes for programmed-I/O task-file accesses on a two-channel parallel ATA port. Every access runs three phases in a fixed order: address setup with chip-select asserted, an active phase with the read or write strobe asserted, and a recovery phase. The block then raises a one-cycle completion pulse. The length of each phase comes from byte-wide timing registers, which are written over a small register port and decoded in hardware.

The primary channel keeps an individual timing set for each of its two drives. The secondary channel has one set that both of its drives use. Accesses to the command block take their active and recovery lengths from a dedicated command-timing register, so that software can keep those accesses slow while data-register accesses run faster. A revision input selects between the two silicon variants, which differ in how recovery is counted.

Top module: `ide_pio_timer`

## Requirements
- R1: In each setup register, bits [7:6] select the address-setup length as follows: 00 gives 4 clocks, 10 gives 3, 01 gives 2 and 11 gives 5. Bits [5:0] are stored and read back unchanged.
- R2: A packed timing byte holds the active length in bits [7:4] and the recovery length in bits [3:0]. A nibble value of 0 means 16 clocks.
- R3: When rev_code is greater than 1, the recovery phase lasts one clock longer than the decoded count, so a nibble of 0 gives 17 clocks.
- R4: The register map is as follows. Address 0 holds the drive 0 setup register and address 1 its packed timing byte. Addresses 2 and 3 hold the same pair for drive 1. Addresses 4 and 5 hold the pair that drives 2 and 3 share. Drives 0 and 1 assert cs[0], and drives 2 and 3 assert cs[1].
- R5: The active phase lasts at least 2 clocks, so an active nibble of 1 gives 2.
- R6: When the decoded active length exceeds 3 and the recovery nibble is 1, recovery lasts 2 clocks. This adjustment is made before any revision extension.
- R7: An access with req_cmd set takes its active and recovery lengths from the command-timing register at address 6, and its setup length from the addressed drive's setup register. That register's reset value of 0 gives 16/16.
- R8: After reset every register reads 0, so every drive runs setup 4, active 16 and recovery 16.
- R9: ack equals req in any cycle in which the block is idle. It is 0 during an access and during the done cycle, and a request raised at those times is not started.
- R10: An accepted access starts setup on the next cycle. The phases then run in the order setup, active, recovery, and done is high for exactly one cycle right after recovery, with chip-select already low.
- R11: The selected chip-select is high from the first setup cycle to the last recovery cycle. wr_stb (req_write=1) or rd_stb (req_write=0) is high only during the active phase, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rev_code | input | 2 | Silicon revision code |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| req | input | 1 | Access request |
| req_drive | input | 2 | Drive index, 0 to 3 |
| req_write | input | 1 | 1 for a write strobe, 0 for a read strobe |
| req_cmd | input | 1 | Access targets the command block |
| ack | output | 1 | Request accepted this cycle |
| cs | output | 2 | Chip-select per channel |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: three timing sets, a 3-bit address and a 5-bit phase counter. The 5-bit counter covers the longest recovery of 17 clocks, which rev_code 2 with a zero nibble produces, so that corner lies inside the directed cases. Each of the four setup codes is measured, along with the nibble-zero, active-of-one and recovery-bump rules, by counting chip-select and strobe cycles at the ports. Further cases cover the sharing between drives 2 and 3 and the rejection of requests while the block is busy.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_RECOV  = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } ptime_t;

  // Two-bit setup code; the mapping is deliberately non-monotonic.
  function automatic logic [CNT_W-1:0] setup_len(input logic [1:0] code);
    logic [CNT_W-1:0] len;
    case (code)
      2'b00:   len = CNT_W'(4);
      2'b10:   len = CNT_W'(3);
      2'b01:   len = CNT_W'(2);
      default: len = CNT_W'(5);
    endcase
    return len;
  endfunction

  // Nibble to clock count, zero standing for sixteen.
  function automatic logic [CNT_W-1:0] nib_len(input logic [3:0] nib);
    logic [CNT_W-1:0] len;
    if (nib == 4'd0) len = CNT_W'(16);
    else             len = CNT_W'(nib);
    return len;
  endfunction

endpackage

// File: rtl/ide_tim_regs.sv
module ide_tim_regs
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NSETS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        setup_q [NSETS],
  output logic [7:0]        pack_q  [NSETS],
  output logic [7:0]        cmd_q,
  output logic [7:0]        rdata
);

  localparam int CMD_ADDR = 2 * NSETS;

  generate
    for (genvar g = 0; g < NSETS; g++) begin : g_set
      logic setup_en;
      logic pack_en;
      assign setup_en = we && (addr == ADDR_W'(2 * g));
      assign pack_en  = we && (addr == ADDR_W'(2 * g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          setup_q[g] <= 8'h00;
        end else if (setup_en) begin
          setup_q[g] <= wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pack_q[g] <= 8'h00;
        end else if (pack_en) begin
          pack_q[g] <= wdata;
        end
      end
    end
  endgenerate

  logic cmd_en;
  assign cmd_en = we && (addr == ADDR_W'(CMD_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 8'h00;
    end else if (cmd_en) begin
      cmd_q <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NSETS; i++) begin
      if (addr == ADDR_W'(2 * i))     rdata = setup_q[i];
      if (addr == ADDR_W'(2 * i + 1)) rdata = pack_q[i];
    end
    if (addr == ADDR_W'(CMD_ADDR)) rdata = cmd_q;
  end

endmodule

// File: rtl/ide_tim_decode.sv
module ide_tim_decode
  import ide_pio_pkg::*;
#(
  parameter int REV_THRESH = 1
) (
  input  logic [7:0] setup_byte,
  input  logic [7:0] pack_byte,
  input  logic [7:0] cmd_byte,
  input  logic       use_cmd,
  input  logic [1:0] rev_code,
  output ptime_t     tim
);

  logic [7:0]       pk;
  logic [CNT_W-1:0] act_raw;
  logic [CNT_W-1:0] act_len;
  logic [CNT_W-1:0] rec_raw;
  logic [CNT_W-1:0] rec_bump;
  logic [CNT_W-1:0] rec_len;

  always_comb begin
    pk      = use_cmd ? cmd_byte : pack_byte;
    act_raw = nib_len(pk[7:4]);
    rec_raw = nib_len(pk[3:0]);

    // Active floor of two clocks.
    if (act_raw == CNT_W'(1)) act_len = CNT_W'(2);
    else                      act_len = act_raw;

    // A long active phase cannot be followed by a single recovery clock.
    if ((act_len > CNT_W'(3)) && (rec_raw == CNT_W'(1))) rec_bump = CNT_W'(2);
    else                                                  rec_bump = rec_raw;

    // Later revisions count one extra recovery clock.
    if (rev_code > 2'(REV_THRESH)) rec_len = rec_bump + CNT_W'(1);
    else                           rec_len = rec_bump;

    tim.setup  = setup_len(setup_byte[7:6]);
    tim.active = act_len;
    tim.recov  = rec_len;
  end

endmodule

// File: rtl/ide_strobe_fsm.sv
module ide_strobe_fsm
  import ide_pio_pkg::*;
#(
  parameter int NCHAN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_write,
  input  logic             req_chan,
  input  ptime_t           tim,
  output logic             ack,
  output logic [NCHAN-1:0] cs,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  ptime_t           tim_q;
  logic             wr_q;
  logic             chan_q;
  logic             load_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          load_en = 1'b1;
          phase_d = PH_SETUP;
          cnt_d   = tim.setup - ONE;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = tim_q.active - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          phase_d = PH_RECOV;
          cnt_d   = tim_q.recov - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          phase_d = PH_DONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q  <= '0;
      wr_q   <= 1'b0;
      chan_q <= 1'b0;
    end else if (load_en) begin
      tim_q  <= tim;
      wr_q   <= req_write;
      chan_q <= req_chan;
    end
  end

  logic in_access;
  assign in_access = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE) ||
                     (phase_q == PH_RECOV);

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_cs
      assign cs[c] = in_access && (chan_q == 1'(c));
    end
  endgenerate

  assign ack    = load_en;
  assign rd_stb = (phase_q == PH_ACTIVE) && !wr_q;
  assign wr_stb = (phase_q == PH_ACTIVE) && wr_q;
  assign done   = (phase_q == PH_DONE);

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int NSETS      = 3,
  parameter int REV_THRESH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rev_code,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req,
  input  logic [1:0]        req_drive,
  input  logic              req_write,
  input  logic              req_cmd,
  output logic              ack,
  output logic [1:0]        cs,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done
);

  localparam int SHARED_SET = NSETS - 1;
  localparam int SEL_W      = $clog2(NSETS);

  // Reset synchronizer: asserts asynchronously, releases on a clock edge.
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  logic [7:0] setup_q [NSETS];
  logic [7:0] pack_q  [NSETS];
  logic [7:0] cmd_q;

  ide_tim_regs #(.ADDR_W(ADDR_W), .NSETS(NSETS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .setup_q (setup_q),
    .pack_q  (pack_q),
    .cmd_q   (cmd_q),
    .rdata   (cfg_rdata)
  );

  // Drive to timing set: each primary drive owns one, the secondary pair shares the last.
  logic [SEL_W-1:0] set_sel;
  logic             req_chan;
  always_comb begin
    req_chan = req_drive[1];
    if (req_drive[1]) set_sel = SEL_W'(SHARED_SET);
    else              set_sel = SEL_W'(req_drive[0]);
  end

  ptime_t tim;
  ide_tim_decode #(.REV_THRESH(REV_THRESH)) u_dec (
    .setup_byte (setup_q[set_sel]),
    .pack_byte  (pack_q[set_sel]),
    .cmd_byte   (cmd_q),
    .use_cmd    (req_cmd),
    .rev_code   (rev_code),
    .tim        (tim)
  );

  ide_strobe_fsm #(.NCHAN(2)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .req       (req),
    .req_write (req_write),
    .req_chan  (req_chan),
    .tim       (tim),
    .ack       (ack),
    .cs        (cs),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .done      (done)
  );

endmodule

// File: rtl/ide_pio_timer_chk.sv
module ide_pio_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic [1:0] cs,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       done
);

  AST_STB_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (|cs)); // R11

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb})); // R11

  AST_CS_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cs == 2'b00) && ($past(cs) != 2'b00))); // R10

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cs) || done) |-> !ack); // R9

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((|cs) && !rd_stb && !wr_stb)); // R10

endmodule

bind ide_pio_timer ide_pio_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .ack    (ack),
  .cs     (cs),
  .rd_stb (rd_stb),
  .wr_stb (wr_stb),
  .done   (done)
);

// File: tb/ide_pio_timer_bench.sv
module ide_pio_timer_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] rev_code;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       req;
  logic [1:0] req_drive;
  logic       req_write;
  logic       req_cmd;
  logic       ack;
  logic [1:0] cs;
  logic       rd_stb;
  logic       wr_stb;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;

  ide_pio_timer u_ide_pio_timer (
    .clk, .rst_n, .rev_code, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req, .req_drive, .req_write, .req_cmd, .ack, .cs, .rd_stb, .wr_stb, .done
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, tag, cfg_rdata, e);
  endtask

  // Runs one access and measures each phase at the ports.
  task automatic run_acc(input logic [1:0] drv, input bit wr, input bit cmd,
                         input int es, input int ea, input int er, input string tag);
    int s = 0, a = 0, r = 0, guard = 0;
    bit order_ok = 1, stb_ok = 1, cs_ok = 1;
    logic [1:0] exp_cs;
    exp_cs = drv[1] ? 2'b10 : 2'b01;
    @(negedge clk);
    req = 1'b1; req_drive = drv; req_write = wr; req_cmd = cmd;
    #1;
    chk(ack == 1'b1, {tag, " R9 ack when idle"}, ack, 1);
    @(negedge clk);
    req = 1'b0;
    while (!done && guard < 200) begin
      if (rd_stb || wr_stb) begin
        if (r != 0) order_ok = 0;
        if (wr_stb != wr || rd_stb == wr) stb_ok = 0;
        a++;
      end else if (cs != 2'b00) begin
        if (a == 0) s++; else r++;
      end else begin
        order_ok = 0;
      end
      if (cs != exp_cs) cs_ok = 0;
      guard++;
      @(negedge clk);
    end
    chk(s == es, {tag, " setup length"}, s, es);
    chk(a == ea, {tag, " active length"}, a, ea);
    chk(r == er, {tag, " recovery length"}, r, er);
    chk(order_ok, {tag, " R10 phase order"}, order_ok, 1);
    chk(stb_ok && cs_ok, {tag, " R11 strobe/cs"}, {stb_ok, cs_ok}, 3);
    chk(done && cs == 2'b00, {tag, " R10 done with cs low"}, {done, cs}, 4);
    @(negedge clk);
    chk(!done, {tag, " R10 done single cycle"}, done, 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) rd_chk(3'(i), 8'h00, "R8 reset value");
    chk(cs == 2'b00 && !rd_stb && !wr_stb && !done, "R8 idle outputs", {cs, rd_stb, wr_stb, done}, 0);
    run_acc(2'd0, 1'b0, 1'b0, 4, 16, 16, "R8 default drive0");
    run_acc(2'd3, 1'b1, 1'b0, 4, 16, 16, "R8 default drive3");
  endtask

  task automatic t_setup_codes;
    wr_reg(3'd2, 8'h2A);
    rd_chk(3'd2, 8'h2A, "R1 low bits kept");
    run_acc(2'd1, 1'b0, 1'b0, 4, 16, 16, "R1 code00");
    wr_reg(3'd2, 8'hAA);
    rd_chk(3'd2, 8'hAA, "R1 readback");
    run_acc(2'd1, 1'b0, 1'b0, 3, 16, 16, "R1 code10");
    wr_reg(3'd2, 8'h6A);
    run_acc(2'd1, 1'b1, 1'b0, 2, 16, 16, "R1 code01");
    wr_reg(3'd2, 8'hEA);
    run_acc(2'd1, 1'b1, 1'b0, 5, 16, 16, "R1 code11");
  endtask

  task automatic t_nibbles;
    wr_reg(3'd3, 8'h35);
    run_acc(2'd1, 1'b0, 1'b0, 5, 3, 5, "R2 nibbles 3/5");
    wr_reg(3'd3, 8'hF0);
    run_acc(2'd1, 1'b0, 1'b0, 5, 15, 16, "R2 zero recovery");
    wr_reg(3'd3, 8'h14);
    run_acc(2'd1, 1'b1, 1'b0, 5, 2, 4, "R5 active floor");
    wr_reg(3'd3, 8'h41);
    run_acc(2'd1, 1'b0, 1'b0, 5, 4, 2, "R6 recovery bump");
    wr_reg(3'd3, 8'h31);
    run_acc(2'd1, 1'b0, 1'b0, 5, 3, 1, "R6 no bump at active 3");
  endtask

  task automatic t_revision;
    rev_code = 2'd2;
    wr_reg(3'd3, 8'h35);
    run_acc(2'd1, 1'b0, 1'b0, 5, 3, 6, "R3 rev2 plus one");
    wr_reg(3'd3, 8'h00);
    run_acc(2'd1, 1'b0, 1'b0, 5, 16, 17, "R3 rev2 max");
    wr_reg(3'd3, 8'h41);
    run_acc(2'd1, 1'b0, 1'b0, 5, 4, 3, "R3 rev2 after bump");
    rev_code = 2'd1;
  endtask

  task automatic t_channels;
    wr_reg(3'd0, 8'h40);
    wr_reg(3'd1, 8'h22);
    wr_reg(3'd4, 8'h80);
    wr_reg(3'd5, 8'h63);
    run_acc(2'd0, 1'b0, 1'b0, 2, 2, 2, "R4 drive0 own set");
    run_acc(2'd1, 1'b0, 1'b0, 5, 4, 2, "R4 drive1 own set");
    run_acc(2'd2, 1'b1, 1'b0, 3, 6, 3, "R4 drive2 shared");
    run_acc(2'd3, 1'b0, 1'b0, 3, 6, 3, "R4 drive3 shared");
  endtask

  task automatic t_command;
    run_acc(2'd0, 1'b0, 1'b1, 2, 16, 16, "R7 cmd reset slowest");
    wr_reg(3'd6, 8'h52);
    run_acc(2'd2, 1'b1, 1'b1, 3, 5, 2, "R7 cmd register");
    run_acc(2'd2, 1'b1, 1'b0, 3, 6, 3, "R7 data uses drive set");
  endtask

  task automatic t_busy;
    bit seen = 0;
    @(negedge clk);
    req = 1'b1; req_drive = 2'd0; req_write = 1'b0; req_cmd = 1'b0;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; req_drive = 2'd2; req_write = 1'b1;
    #1;
    chk(ack == 1'b0, "R9 no ack while busy", ack, 0);
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    #1;
    chk(done && ack == 1'b0, "R9 no ack in done cycle", {done, ack}, 2);
    req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cs != 2'b00 || wr_stb) seen = 1;
    end
    chk(!seen, "R9 busy request not started", seen, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rev_code = 2'd1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req = 1'b0; req_drive = '0; req_write = 1'b0; req_cmd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup_codes();
    t_nibbles();
    t_revision();
    t_channels();
    t_command();
    t_busy();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule